// File: doc/BRIEF.md
# Single-wire return-to-one host controller

This block is the host end of a one-wire, open-drain serial link that uses return-to-one bit framing. Each request is one register access. The controller can optionally start with a break and recovery interval. It then shifts out a command byte that holds a direction flag and a 7-bit register address. On a write it then shifts out the data byte. On a read it releases the line and measures the low pulses that the remote device sends back.

Every timing figure is a parameter counted in clock cycles, so the same logic serves any system clock. The host pulls the wire low through `line_pd_o` and watches the wire through `line_i`. A write can ask for a verify pass. In that pass the controller reads the same register back and flags any difference. A read whose remote side stalls ends with an error flag, and the next access should then request a break.

Top module: `rto_host_ctrl`

## Requirements
- R1: The command byte has the direction flag in bit 7 (1 = write, 0 = read) and the address in bits 6:0. Command and data bytes go out least-significant bit first.
- R2: Every bit the host sends begins with a low pulse. The pulse lasts `T_STRT` cycles for a 1 and `T_ZERO` cycles for a 0. The line is then released until `T_CYC` cycles have passed from that falling edge.
- R3: On a write, the data byte follows the command byte. `ack_o` follows the last data bit cycle unless a verify pass was requested.
- R4: When `brk_i` is set with the request, the line is held low for `T_BRK` cycles and then released for at least `T_BRKR` cycles before the first command bit. Without `brk_i`, no break is sent.
- R5: On a read, each returned low pulse shorter than `RX_THR` cycles decodes as 1, and any longer pulse decodes as 0. Bits are taken LSB first, and the byte appears on `rdata_o` with `ack_o`.
- R6: The host never pulls the line while it is idle or while it receives read data.
- R7: During a read, if `RX_TMO` cycles pass after the read phase starts or after the last falling edge without the next bit completing, the access ends with `ack_o` and `err_o` = 1. An access that completes normally clears `err_o`.
- R8: A write with `verify_i` set is followed by a read command (bit 7 = 0) to the same address. `mismatch_o` is 1 exactly when the returned byte differs from the written one, and `rdata_o` takes the returned byte.
- R9: `ack_o` is a one-cycle pulse, given once per accepted request. `rdata_o`, `err_o` and `mismatch_o` change only in the `ack_o` cycle and hold their values between accesses. A failed read leaves `rdata_o` unchanged.
- R10: A request raised while an access is in progress is ignored: it sends no command and produces no acknowledge.
- R11: During reset the line is released and `ack_o`, `rdata_o`, `err_o` and `mismatch_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an access (taken only when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Register address |
| wdata_i | input | 8 | Write data |
| brk_i | input | 1 | Send a break before the command |
| verify_i | input | 1 | After a write, read back and compare |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte returned by the last read or verify |
| err_o | output | 1 | Last access ended in a read timeout |
| mismatch_o | output | 1 | Verify read differed from written data |
| line_i | input | 1 | Level of the shared wire |
| line_pd_o | output | 1 | Pull the wire low when 1 |

## Verification
Results arrive with `ack_o`. For a write that is a few cycles after the last data bit cycle, and for a read a few cycles after the last returned pulse rises. The bench therefore waits for the acknowledge within a bounded number of cycles instead of counting a fixed latency. It samples the outputs on the falling clock edge of that same cycle, and again one cycle later to confirm the pulse has dropped. A remote-device model measures each host low pulse and each falling-edge spacing to the exact cycle at falling edges. It compares them with `T_STRT`, `T_ZERO`, `T_CYC`, `T_BRK` and `T_BRKR`, and returns bytes whose pulse widths sit clearly on either side of `RX_THR`.

// File: rtl/rto_pkg.sv
package rto_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_CMD,
    ST_WDAT,
    ST_RD
  } rto_state_e;
endpackage

// File: rtl/rto_tx.sv
module rto_tx #(
  parameter int unsigned T_CYC  = 40,
  parameter int unsigned T_STRT = 4,
  parameter int unsigned T_ZERO = 24,
  parameter int unsigned T_BRK  = 64,
  parameter int unsigned T_BRKR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       brk_i,
  input  logic [7:0] byte_i,
  output logic       pd_o,
  output logic       done_o
);
  localparam int unsigned T_BRKT = T_BRK + T_BRKR;
  localparam int unsigned T_MAX  = (T_CYC > T_BRKT) ? T_CYC : T_BRKT;
  localparam int unsigned CW     = $clog2(T_MAX + 1);
  localparam logic [CW-1:0] CYC_END = CW'(T_CYC - 1);
  localparam logic [CW-1:0] BRK_END = CW'(T_BRKT - 1);
  localparam logic [CW-1:0] STRT_L  = CW'(T_STRT);
  localparam logic [CW-1:0] ZERO_L  = CW'(T_ZERO);
  localparam logic [CW-1:0] BRK_L   = CW'(T_BRK);

  logic          busy_q, brk_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    idx_q;
  logic [7:0]    sr_q;

  always_comb begin
    if (!busy_q)    pd_o = 1'b0;
    else if (brk_q) pd_o = cnt_q < BRK_L;
    else            pd_o = (cnt_q < STRT_L) || (!sr_q[0] && cnt_q < ZERO_L);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      brk_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        brk_q  <= brk_i;
        cnt_q  <= '0;
        idx_q  <= '0;
        sr_q   <= byte_i;
      end else if (busy_q) begin
        if (brk_q) begin
          if (cnt_q == BRK_END) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (cnt_q == CYC_END) begin
          cnt_q <= '0;
          sr_q  <= {1'b0, sr_q[7:1]};  // LSB first
          idx_q <= idx_q + 3'd1;
          if (idx_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;

  assert_start_pulls_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> pd_o);
endmodule

// File: rtl/rto_rx.sv
module rto_rx #(
  parameter int unsigned RX_THR = 12,
  parameter int unsigned RX_TMO = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       line_i,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] byte_o
);
  localparam int unsigned CW = $clog2(RX_TMO + 1);
  localparam logic [CW-1:0] THR_L   = CW'(RX_THR);
  localparam logic [CW-1:0] TMO_END = CW'(RX_TMO - 1);

  logic          s1_q, s2_q;
  logic          act_q, low_q, done_q, err_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    n_q;
  logic [7:0]    sr_q;

  // two-flop synchronizer, idle level high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
    end
  end

  // cnt_q runs from the last falling edge (or read start) through the bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      low_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      n_q    <= '0;
      sr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start_i) begin
        act_q <= 1'b1;
        low_q <= 1'b0;
        cnt_q <= '0;
        n_q   <= '0;
      end else if (act_q) begin
        if (cnt_q == TMO_END) begin
          act_q <= 1'b0;
          err_q <= 1'b1;
        end else if (!low_q) begin
          if (!s2_q) begin
            low_q <= 1'b1;
            cnt_q <= {{(CW-1){1'b0}}, 1'b1};
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (s2_q) begin
          sr_q  <= {cnt_q < THR_L, sr_q[7:1]};
          n_q   <= n_q + 3'd1;
          low_q <= 1'b0;
          cnt_q <= cnt_q + 1'b1;
          if (n_q == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
  assign byte_o = sr_q;

  assert_single_outcome_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
endmodule

// File: rtl/rto_host_ctrl.sv
module rto_host_ctrl
  import rto_pkg::*;
#(
  parameter int unsigned T_CYC  = 40,
  parameter int unsigned T_STRT = 4,
  parameter int unsigned T_ZERO = 24,
  parameter int unsigned T_BRK  = 64,
  parameter int unsigned T_BRKR = 16,
  parameter int unsigned RX_THR = 12,
  parameter int unsigned RX_TMO = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              brk_i,
  input  logic              verify_i,
  output logic              ack_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              err_o,
  output logic              mismatch_o,
  input  logic              line_i,
  output logic              line_pd_o
);
  rto_state_e        st_q;
  logic              wr_q, verify_q, vphase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q, tx_byte_q, rdata_q;
  logic              tx_start_q, tx_brk_q, rx_start_q;
  logic              ack_q, err_q, mism_q;
  logic              tx_done, rx_done, rx_err;
  logic [BYTE_W-1:0] rx_byte;

  rto_tx #(
    .T_CYC (T_CYC),
    .T_STRT(T_STRT),
    .T_ZERO(T_ZERO),
    .T_BRK (T_BRK),
    .T_BRKR(T_BRKR)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start_q),
    .brk_i  (tx_brk_q),
    .byte_i (tx_byte_q),
    .pd_o   (line_pd_o),
    .done_o (tx_done)
  );

  rto_rx #(
    .RX_THR(RX_THR),
    .RX_TMO(RX_TMO)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(rx_start_q),
    .line_i (line_i),
    .done_o (rx_done),
    .err_o  (rx_err),
    .byte_o (rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      wr_q       <= 1'b0;
      verify_q   <= 1'b0;
      vphase_q   <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      tx_byte_q  <= '0;
      tx_start_q <= 1'b0;
      tx_brk_q   <= 1'b0;
      rx_start_q <= 1'b0;
      ack_q      <= 1'b0;
      rdata_q    <= '0;
      err_q      <= 1'b0;
      mism_q     <= 1'b0;
    end else begin
      tx_start_q <= 1'b0;
      rx_start_q <= 1'b0;
      ack_q      <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          wr_q       <= wr_i;
          addr_q     <= addr_i;
          wdata_q    <= wdata_i;
          verify_q   <= verify_i & wr_i;
          vphase_q   <= 1'b0;
          tx_start_q <= 1'b1;
          tx_brk_q   <= brk_i;
          tx_byte_q  <= {wr_i, addr_i};
          st_q       <= brk_i ? ST_BRK : ST_CMD;
        end
        ST_BRK: if (tx_done) begin
          st_q       <= ST_CMD;
          tx_start_q <= 1'b1;
          tx_brk_q   <= 1'b0;
          tx_byte_q  <= {wr_q, addr_q};
        end
        ST_CMD: if (tx_done) begin
          if (wr_q && !vphase_q) begin
            st_q       <= ST_WDAT;
            tx_start_q <= 1'b1;
            tx_byte_q  <= wdata_q;
          end else begin
            st_q       <= ST_RD;
            rx_start_q <= 1'b1;
          end
        end
        ST_WDAT: if (tx_done) begin
          if (verify_q) begin
            vphase_q   <= 1'b1;
            st_q       <= ST_CMD;
            tx_start_q <= 1'b1;
            tx_byte_q  <= {1'b0, addr_q};
          end else begin
            st_q   <= ST_IDLE;
            ack_q  <= 1'b1;
            err_q  <= 1'b0;
            mism_q <= 1'b0;
          end
        end
        ST_RD: if (rx_err) begin
          st_q   <= ST_IDLE;
          ack_q  <= 1'b1;
          err_q  <= 1'b1;
          mism_q <= 1'b0;
        end else if (rx_done) begin
          st_q    <= ST_IDLE;
          ack_q   <= 1'b1;
          err_q   <= 1'b0;
          rdata_q <= rx_byte;
          mism_q  <= vphase_q && (rx_byte != wdata_q);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o      = ack_q;
  assign rdata_o    = rdata_q;
  assign err_o      = err_q;
  assign mismatch_o = mism_q;

  assert_idle_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !line_pd_o);
  assert_rd_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD) |-> !line_pd_o);
  assert_ack_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  assert_err_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_o) |-> ack_o);
  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> ack_o);
  assert_err_no_mismatch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && err_o) |-> !mismatch_o);
endmodule

// File: tb/rto_host_ctrl_tb_top.sv
module rto_host_ctrl_tb_top;
  localparam int T_CYC = 40, T_STRT = 4, T_ZERO = 24, T_BRK = 64, T_BRKR = 16;
  localparam int RX_THR = 12, RX_TMO = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       req = 1'b0, wr = 1'b0, brk = 1'b0, verify = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       ack, err, mism, pd, line;
  logic [7:0] rdata;
  logic       slave_pd = 1'b0;
  assign line = ~(pd | slave_pd);

  rto_host_ctrl #(
    .T_CYC(T_CYC), .T_STRT(T_STRT), .T_ZERO(T_ZERO), .T_BRK(T_BRK),
    .T_BRKR(T_BRKR), .RX_THR(RX_THR), .RX_TMO(RX_TMO)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .brk_i(brk), .verify_i(verify), .ack_o(ack),
    .rdata_o(rdata), .err_o(err), .mismatch_o(mism), .line_i(line),
    .line_pd_o(pd)
  );

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // remote device model
  int         cyc = 0, fall_cyc = 0, prev_fall = 0, w = 0, nbits = 0;
  logic       pd_prev = 1'b0;
  logic [7:0] sr = '0, data_log = '0, resp_byte = '0;
  logic [7:0] cmd_log [4];
  logic [6:0] cur_addr = '0;
  bit         exp_data = 0, first_pending = 1, corrupt = 0, resp_active = 0, tb_idle = 1;
  int         brk_cnt = 0, brk_w = 0, brk_end = 0, first_fall = 0, bad_w = 0, bad_sp = 0;
  int         n_cmd = 0, n_data = 0, lim = 8, resp_t0 = 0, rel = 0, k = 0, ph = 0;
  int         acks = 0, ovl_viol = 0, idle_viol = 0;
  logic [7:0] smem [128];
  logic [7:0] exp_mem [128];

  always @(negedge clk) begin
    cyc++;
    if (ack) acks++;
    if (pd && slave_pd) ovl_viol++;
    if (tb_idle && pd) idle_viol++;
    if (pd && !pd_prev) begin
      prev_fall = fall_cyc;
      fall_cyc = cyc;
    end
    if (!pd && pd_prev) begin
      w = cyc - fall_cyc;
      if (w >= 40) begin
        brk_cnt++; brk_w = w; brk_end = cyc; nbits = 0; exp_data = 0;
        resp_active = 0; first_pending = 1;
      end else begin
        if (first_pending) begin first_fall = fall_cyc; first_pending = 0; end
        if (w != T_STRT && w != T_ZERO) bad_w++;
        if (nbits % 8 != 0 && fall_cyc - prev_fall != T_CYC) bad_sp++;
        sr = {(w < 14), sr[7:1]};
        nbits++;
        if (nbits % 8 == 0) begin
          if (exp_data) begin
            data_log = sr; n_data++;
            smem[cur_addr] = corrupt ? (sr ^ 8'h01) : sr;
            exp_data = 0;
          end else begin
            if (n_cmd < 4) cmd_log[n_cmd] = sr;
            n_cmd++;
            cur_addr = sr[6:0];
            if (sr[7]) exp_data = 1;
            else begin
              resp_active = 1;
              resp_t0 = fall_cyc + T_CYC + 10;
              resp_byte = smem[sr[6:0]];
            end
          end
        end
      end
    end
    pd_prev = pd;
    if (resp_active) begin
      rel = cyc - resp_t0;
      if (rel < 0) slave_pd = 1'b0;
      else begin
        k = rel / T_CYC; ph = rel % T_CYC;
        if (k >= 8) begin resp_active = 0; slave_pd = 1'b0; end
        else slave_pd = (k < lim) && (ph < (resp_byte[3'(k)] ? 3 : 16));
      end
    end else slave_pd = 1'b0;
  end

  logic [7:0] last_rd = '0;
  bit         last_e = 0;
  int         n_txn = 0;

  task automatic txn(input bit w_i, input logic [6:0] a, input logic [7:0] d,
                     input bit b, input bit v, input int poke_at,
                     output logic [7:0] rd, output bit e, output bit m);
    bit got;
    @(negedge clk);
    n_cmd = 0; n_data = 0; brk_cnt = 0; bad_w = 0; bad_sp = 0; first_pending = 1;
    tb_idle = 0;
    req = 1'b1; wr = w_i; addr = a; wdata = d; brk = b; verify = v;
    n_txn++;
    @(negedge clk);
    req = 1'b0;
    got = 0; rd = '0; e = 0; m = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i == poke_at) begin req = 1'b1; wr = 1'b1; addr = 7'd21; end
      if (i == poke_at + 1) req = 1'b0;
      if (i == 50) check(rdata == last_rd && err == last_e, "R9 outputs held mid-access",
                         int'(rdata), int'(last_rd));
      if (ack) begin got = 1; rd = rdata; e = err; m = mism; break; end
    end
    check(got, "R9 ack received", int'(got), 1);
    @(negedge clk);
    check(!ack, "R9 ack one cycle", int'(ack), 0);
    tb_idle = 1;
    last_rd = rd; last_e = e;
  endtask

  logic [7:0] rd;
  bit         e, m;
  logic [6:0] a;
  logic [7:0] d;
  int         acks0;

  initial begin
    for (int i = 0; i < 128; i++) begin
      smem[i] = 8'(i * 3) ^ 8'h5A;
      exp_mem[i] = smem[i];
    end
    repeat (5) @(negedge clk);
    check(!pd && !ack && rdata == 8'h00 && !err && !mism, "R11 reset outputs",
          int'({pd, ack, err, mism}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // write sweep
    for (int i = 0; i < 34; i++) begin
      a = (i < 32) ? 7'((i * 37 + 3) % 128) : (i == 32 ? 7'd127 : 7'd0);
      d = (i < 32) ? 8'(i * 29 + 7) : (i == 32 ? 8'h00 : 8'hFF);
      txn(1, a, d, i == 0 || i == 33, 0, -5, rd, e, m);
      check(n_cmd == 1 && cmd_log[0] == {1'b1, a}, "R1 write command byte",
            int'(cmd_log[0]), int'({1'b1, a}));
      check(n_data == 1 && data_log == d, "R3 write data byte", int'(data_log), int'(d));
      check(bad_w == 0 && bad_sp == 0, "R2 bit pulse widths and spacing", bad_w + bad_sp, 0);
      check(brk_cnt == ((i == 0 || i == 33) ? 1 : 0), "R4 break only on request",
            brk_cnt, (i == 0 || i == 33) ? 1 : 0);
      if (i == 0 || i == 33) begin
        check(brk_w == T_BRK, "R4 break low width", brk_w, T_BRK);
        check(first_fall - brk_end >= T_BRKR, "R4 break recovery", first_fall - brk_end, T_BRKR);
      end
      check(!e && !m, "R7 clean write flags", int'({e, m}), 0);
      exp_mem[a] = d;
    end

    // read sweep, written and untouched addresses
    for (int i = 0; i < 34; i++) begin
      a = (i < 32) ? ((i % 2 == 1) ? 7'((i * 37 + 3) % 128) : 7'((i * 37 + 70) % 128))
                   : (i == 32 ? 7'd127 : 7'd0);
      txn(0, a, 8'h00, i % 8 == 3, 0, -5, rd, e, m);
      check(n_cmd == 1 && cmd_log[0] == {1'b0, a}, "R1 read command byte",
            int'(cmd_log[0]), int'({1'b0, a}));
      check(rd == exp_mem[a], "R5 read data decode", int'(rd), int'(exp_mem[a]));
      check(!e && !m, "R7 clean read flags", int'({e, m}), 0);
    end

    // verify pass, matching
    txn(1, 7'd5, 8'hA5, 0, 1, -5, rd, e, m);
    check(n_cmd == 2 && cmd_log[1] == 8'h05, "R8 verify read command",
          int'(cmd_log[1]), 5);
    check(!m && rd == 8'hA5, "R8 verify match", int'({m, rd}), 8'hA5);
    exp_mem[5] = 8'hA5;

    // verify pass, corrupted store
    corrupt = 1;
    txn(1, 7'd9, 8'h3C, 0, 1, -5, rd, e, m);
    corrupt = 0;
    check(m && rd == 8'h3D, "R8 verify mismatch", int'({m, rd}), 9'h13D);
    exp_mem[9] = 8'h3D;

    // stall after three bits
    lim = 3;
    txn(0, 7'd10, 8'h00, 1, 0, -5, rd, e, m);
    check(e && !m, "R7 timeout mid-byte", int'(e), 1);
    check(rdata == 8'h3D, "R9 rdata kept on error", int'(rdata), 8'h3D);
    repeat (500) @(negedge clk);
    // no response at all
    lim = 0;
    txn(0, 7'd11, 8'h00, 1, 0, -5, rd, e, m);
    check(e, "R7 timeout no response", int'(e), 1);
    repeat (500) @(negedge clk);
    lim = 8;
    txn(0, 7'd10, 8'h00, 1, 0, -5, rd, e, m);
    check(!e && rd == exp_mem[10], "R7 recovery after break clears error",
          int'({e, rd}), int'(exp_mem[10]));

    // request while busy
    acks0 = acks;
    txn(0, 7'd20, 8'h00, 0, 0, 30, rd, e, m);
    repeat (1500) @(negedge clk);
    check(n_cmd == 1 && cmd_log[0] == 8'h14, "R10 busy request ignored",
          n_cmd, 1);
    check(acks - acks0 == 1, "R10 single ack", acks - acks0, 1);

    check(acks == n_txn, "R9 one ack per access", acks, n_txn);
    check(ovl_viol == 0, "R6 host released during read data", ovl_viol, 0);
    check(idle_viol == 0, "R6 host released while idle", idle_viol, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule